// File: doc/BRIEF.md
# Emulated Printer Handshake Responder

This block stands in for a parallel-port printer behind the standard data, status and control registers. Host software can drive a print job through it with no physical device attached. It sees every register access on a small single-cycle bus. Strobe edges written to the control register capture the data byte, which leaves the block as a byte with a one-cycle valid pulse. The busy and acknowledge status bits then step through a handshake. Each step is paced by a status-register read, not by elapsed time.

Three handshake states make up the status sequence. `HS_BUSY` has busy and ack set, and is the state after reset and after an init request. A strobe write moves `HS_BUSY` to `HS_WAIT_ACK`, where busy is clear and ack is set. A status read with strobe released moves `HS_WAIT_ACK` to `HS_ACK_LOW`, where busy and ack are both clear. A further such read moves `HS_ACK_LOW` back to `HS_BUSY`. An init request returns any state to `HS_BUSY`. An interrupt request is latched when software releases strobe while the interrupt enable was already set. The IRQ output shows that latch, gated by the current enable, until a status read clears it.

Top module: `lpt_printer_model`

## Requirements
- R1: After reset, the status byte is 0xD8, the control register reads 0x0C, the data register reads 0xFF, and irq and out_valid are low.
- R2: Register addresses are 0 for data, 1 for status and 2 for control. rdata shows the addressed register combinationally while rd_en is high. Address 3 reads 0xFF, and a write to address 3 changes nothing.
- R3: A control write with the init bit (bit 2) clear makes the status byte 0xD8 from the next cycle. In that byte, busy is bit 7, ack is bit 6, online is bit 4 and error is bit 3.
- R4: A control write with init, select (bit 3) and strobe (bit 0) all set clears busy from the next cycle, and leaves ack unchanged.
- R5: If that strobe write follows a control value whose strobe bit was clear, out_valid is high for exactly the next cycle and out_byte equals the stored data byte. Otherwise there is no pulse.
- R6: A control write with init and select set and strobe clear sets the interrupt-pending latch if the previous control value had interrupt enable (bit 4) set.
- R7: irq equals the interrupt-pending latch ANDed with bit 4 of the current control register.
- R8: A status read returns the status value from before the read takes effect, and it clears the interrupt-pending latch.
- R9: On a status read with busy clear and control strobe clear, a set ack is cleared, and a clear ack sets both ack and busy. Any other status read leaves the status unchanged.
- R10: A data write stores the byte, and a data read returns it.
- R11: When wr_en and rd_en are high in the same cycle, the write is performed and the read has no side effect.
- R12: A control write with init set and select clear only updates the control register. The status does not change, no byte is captured and no interrupt is latched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe for this cycle |
| rd_en | input | 1 | Register read strobe for this cycle |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while rd_en is high |
| status_o | output | 8 | Current status byte |
| out_byte | output | 8 | Captured print byte |
| out_valid | output | 1 | One-cycle pulse marking a captured byte |
| irq | output | 1 | Interrupt request |

## Verification
Two functions meet on the same status read: that read returns the status value, and on the same edge it clears the interrupt latch and advances the handshake. The bench reads status while an interrupt is pending and while the handshake sits in each state. It checks that rdata holds the value from before the edge, and that status_o and irq show the new values after the edge. The strobe write likewise clears busy and emits the byte on the same edge, and both results are checked in the one cycle that follows. Writing and reading status in the same cycle shows that the read loses its side effect.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_DATA = 2'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] A_CTRL = 2'd2;

    // control bit positions, software polarity
    localparam int C_STROBE = 0;
    localparam int C_AUTOLF = 1;
    localparam int C_INIT   = 2;
    localparam int C_SELIN  = 3;
    localparam int C_IRQEN  = 4;

    // status bit positions, software polarity
    localparam int S_BUSY   = 7;
    localparam int S_ACK    = 6;
    localparam int S_ONLINE = 4;
    localparam int S_ERR    = 3;

    localparam logic [REG_W-1:0] CTRL_RST  = 8'h0C;
    localparam logic [REG_W-1:0] DATA_RST  = 8'hFF;
    localparam logic [REG_W-1:0] OPEN_BUS  = 8'hFF;

    typedef enum logic [1:0] {
        HS_BUSY     = 2'd0,
        HS_WAIT_ACK = 2'd1,
        HS_ACK_LOW  = 2'd2
    } hs_state_e;
endpackage

// File: rtl/lpt_hs_fsm.sv
module lpt_hs_fsm
    import lpt_pkg::*;
#(
    parameter int REG_W = lpt_pkg::REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_req,
    input  logic             strobe_req,
    input  logic             advance_req,
    output hs_state_e        state_o,
    output logic [REG_W-1:0] status_o
);
    hs_state_e state_q;
    hs_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HS_BUSY;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (init_req) begin
            state_d = HS_BUSY;
        end else if (strobe_req) begin
            unique case (state_q)
                HS_BUSY:     state_d = HS_WAIT_ACK;
                HS_WAIT_ACK: state_d = HS_WAIT_ACK;
                HS_ACK_LOW:  state_d = HS_ACK_LOW;
                default:     state_d = HS_BUSY;
            endcase
        end else if (advance_req) begin
            unique case (state_q)
                HS_BUSY:     state_d = HS_BUSY;
                HS_WAIT_ACK: state_d = HS_ACK_LOW;
                HS_ACK_LOW:  state_d = HS_BUSY;
                default:     state_d = HS_BUSY;
            endcase
        end
    end

    // outputs
    always_comb begin
        status_o           = '0;
        status_o[S_ONLINE] = 1'b1;
        status_o[S_ERR]    = 1'b1;
        unique case (state_q)
            HS_BUSY: begin
                status_o[S_BUSY] = 1'b1;
                status_o[S_ACK]  = 1'b1;
            end
            HS_WAIT_ACK: begin
                status_o[S_BUSY] = 1'b0;
                status_o[S_ACK]  = 1'b1;
            end
            HS_ACK_LOW: begin
                status_o[S_BUSY] = 1'b0;
                status_o[S_ACK]  = 1'b0;
            end
            default: begin
                status_o[S_BUSY] = 1'b1;
                status_o[S_ACK]  = 1'b1;
            end
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/lpt_ctrl_regs.sv
module lpt_ctrl_regs
    import lpt_pkg::*;
#(
    parameter int REG_W = lpt_pkg::REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_we,
    input  logic             ctrl_we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] data_q,
    output logic [REG_W-1:0] ctrl_q,
    output logic             init_req,
    output logic             strobe_req,
    output logic             release_req,
    output logic [REG_W-1:0] cap_byte,
    output logic             cap_valid
);
    logic sel_and_init;
    logic first_strobe;

    assign sel_and_init = wdata[C_INIT] && wdata[C_SELIN];
    assign init_req     = ctrl_we && !wdata[C_INIT];
    assign strobe_req   = ctrl_we && sel_and_init && wdata[C_STROBE];
    assign release_req  = ctrl_we && sel_and_init && !wdata[C_STROBE];
    assign first_strobe = strobe_req && !ctrl_q[C_STROBE];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= DATA_RST;
            ctrl_q <= CTRL_RST;
        end else begin
            if (data_we) data_q <= wdata;
            if (ctrl_we) ctrl_q <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_valid <= 1'b0;
            cap_byte  <= '0;
        end else begin
            cap_valid <= first_strobe;
            if (first_strobe) cap_byte <= data_q;
        end
    end
endmodule

// File: rtl/lpt_irq_ctl.sv
module lpt_irq_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic release_req,
    input  logic prev_irqen,
    input  logic stat_rd,
    input  logic cur_irqen,
    output logic irq
);
    logic pending_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                          pending_q <= 1'b0;
        else if (release_req && prev_irqen)  pending_q <= 1'b1;
        else if (stat_rd)                    pending_q <= 1'b0;
    end

    assign irq = pending_q && cur_irqen;
endmodule

// File: rtl/lpt_printer_model.sv
module lpt_printer_model
    import lpt_pkg::*;
#(
    parameter int REG_W  = lpt_pkg::REG_W,
    parameter int ADDR_W = lpt_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic [REG_W-1:0]  status_o,
    output logic [REG_W-1:0]  out_byte,
    output logic              out_valid,
    output logic              irq
);
    logic             data_we;
    logic             ctrl_we;
    logic             stat_rd;
    logic [REG_W-1:0] data_q;
    logic [REG_W-1:0] ctrl_q;
    logic             init_req;
    logic             strobe_req;
    logic             release_req;
    logic             advance_req;
    hs_state_e        hs_state;

    // a write takes the cycle; a read in the same cycle has no side effect
    assign data_we     = wr_en && (addr == A_DATA);
    assign ctrl_we     = wr_en && (addr == A_CTRL);
    assign stat_rd     = rd_en && !wr_en && (addr == A_STAT);
    assign advance_req = stat_rd && !ctrl_q[C_STROBE];

    lpt_ctrl_regs #(.REG_W(REG_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .data_we     (data_we),
        .ctrl_we     (ctrl_we),
        .wdata       (wdata),
        .data_q      (data_q),
        .ctrl_q      (ctrl_q),
        .init_req    (init_req),
        .strobe_req  (strobe_req),
        .release_req (release_req),
        .cap_byte    (out_byte),
        .cap_valid   (out_valid)
    );

    lpt_hs_fsm #(.REG_W(REG_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .init_req    (init_req),
        .strobe_req  (strobe_req),
        .advance_req (advance_req),
        .state_o     (hs_state),
        .status_o    (status_o)
    );

    lpt_irq_ctl u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .release_req (release_req),
        .prev_irqen  (ctrl_q[C_IRQEN]),
        .stat_rd     (stat_rd),
        .cur_irqen   (ctrl_q[C_IRQEN]),
        .irq         (irq)
    );

    always_comb begin
        rdata = OPEN_BUS;
        if (rd_en) begin
            unique case (addr)
                A_DATA:  rdata = data_q;
                A_STAT:  rdata = status_o;
                A_CTRL:  rdata = ctrl_q;
                default: rdata = OPEN_BUS;
            endcase
        end
    end
endmodule

// File: rtl/lpt_printer_checker.sv
module lpt_printer_checker
    import lpt_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       rd_en,
    input logic [1:0] addr,
    input logic [7:0] wdata,
    input logic [7:0] status_o,
    input logic       out_valid,
    input logic       irq,
    input logic [7:0] ctrl_q
);
    a_r3_init_resets_status: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CTRL && !wdata[C_INIT]) |=> (status_o == 8'hD8));

    a_r4_strobe_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CTRL && wdata[C_INIT] && wdata[C_SELIN] && wdata[C_STROBE])
        |=> !status_o[S_BUSY]);

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    a_r5_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(wr_en && addr == A_CTRL && wdata[C_STROBE]));

    a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ctrl_q[C_IRQEN]);

    a_r8_read_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr == A_STAT) |=> !irq);

    a_r9_no_busy_without_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !(status_o[S_BUSY] && !status_o[S_ACK]));

    a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en && addr == A_STAT && irq) |=> irq);
endmodule

bind lpt_printer_model lpt_printer_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .status_o  (status_o),
    .out_valid (out_valid),
    .irq       (irq),
    .ctrl_q    (ctrl_q)
);

// File: tb/lpt_printer_model_test.sv
module lpt_printer_model_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 21;

    typedef struct packed {
        logic       wr;
        logic       rd;
        logic [1:0] a;
        logic [7:0] wd;
        logic [7:0] erd;
        logic [7:0] est;
        logic       ev;
        logic [7:0] eb;
        logic       eirq;
        logic [3:0] req;
    } vec_t;

    localparam vec_t TBL [NV] = '{
        '{1'b1, 1'b0, 2'd0, 8'h41, 8'h00, 8'hD8, 1'b0, 8'h00, 1'b0, 4'd10}, // R10 store data
        '{1'b0, 1'b1, 2'd0, 8'h00, 8'h41, 8'hD8, 1'b0, 8'h00, 1'b0, 4'd10}, // R10 read back
        '{1'b0, 1'b1, 2'd1, 8'h00, 8'hD8, 8'hD8, 1'b0, 8'h00, 1'b0, 4'd9},  // R9 busy: no step
        '{1'b1, 1'b0, 2'd2, 8'h0D, 8'h00, 8'h58, 1'b1, 8'h41, 1'b0, 4'd5},  // R5 capture
        '{1'b0, 1'b1, 2'd1, 8'h00, 8'h58, 8'h58, 1'b0, 8'h00, 1'b0, 4'd9},  // R9 strobe held
        '{1'b1, 1'b0, 2'd2, 8'h1C, 8'h00, 8'h58, 1'b0, 8'h00, 1'b0, 4'd6},  // R6 old enable off
        '{1'b0, 1'b1, 2'd1, 8'h00, 8'h58, 8'h18, 1'b0, 8'h00, 1'b0, 4'd9},  // R9 ack drops
        '{1'b0, 1'b1, 2'd1, 8'h00, 8'h18, 8'hD8, 1'b0, 8'h00, 1'b0, 4'd9},  // R9 ack+busy return
        '{1'b1, 1'b0, 2'd2, 8'h1C, 8'h00, 8'hD8, 1'b0, 8'h00, 1'b1, 4'd6},  // R6 pending set
        '{1'b1, 1'b0, 2'd0, 8'h77, 8'h00, 8'hD8, 1'b0, 8'h00, 1'b1, 4'd7},  // R7 data write keeps irq
        '{1'b1, 1'b0, 2'd2, 8'h0C, 8'h00, 8'hD8, 1'b0, 8'h00, 1'b0, 4'd7},  // R7 enable off masks
        '{1'b1, 1'b0, 2'd2, 8'h1C, 8'h00, 8'hD8, 1'b0, 8'h00, 1'b1, 4'd7},  // R7 enable on unmasks
        '{1'b0, 1'b1, 2'd1, 8'h00, 8'hD8, 8'hD8, 1'b0, 8'h00, 1'b0, 4'd8},  // R8 read clears
        '{1'b1, 1'b0, 2'd2, 8'h1D, 8'h00, 8'h58, 1'b1, 8'h77, 1'b0, 4'd4},  // R4 busy clear
        '{1'b1, 1'b0, 2'd2, 8'h1D, 8'h00, 8'h58, 1'b0, 8'h00, 1'b0, 4'd5},  // R5 no repeat
        '{1'b1, 1'b0, 2'd2, 8'h08, 8'h00, 8'hD8, 1'b0, 8'h00, 1'b0, 4'd3},  // R3 init
        '{1'b1, 1'b0, 2'd2, 8'h05, 8'h00, 8'hD8, 1'b0, 8'h00, 1'b0, 4'd12}, // R12 no select
        '{1'b0, 1'b1, 2'd2, 8'h00, 8'h05, 8'hD8, 1'b0, 8'h00, 1'b0, 4'd2},  // R2 control read
        '{1'b0, 1'b1, 2'd3, 8'h00, 8'hFF, 8'hD8, 1'b0, 8'h00, 1'b0, 4'd2},  // R2 unused address
        '{1'b1, 1'b0, 2'd3, 8'h00, 8'h00, 8'hD8, 1'b0, 8'h00, 1'b0, 4'd2},  // R2 unused write
        '{1'b0, 1'b1, 2'd2, 8'h00, 8'h05, 8'hD8, 1'b0, 8'h00, 1'b0, 4'd2}   // R2 control intact
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] status_o;
    logic [7:0] out_byte;
    logic       out_valid;
    logic       irq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lpt_printer_model uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .status_o  (status_o),
        .out_byte  (out_byte),
        .out_valid (out_valid),
        .irq       (irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // one access: rdata checked before the edge, outputs after it
    task automatic access(input vec_t v);
        string tag;
        tag = $sformatf("R%0d", v.req);
        @(negedge clk);
        wr_en = v.wr; rd_en = v.rd; addr = v.a; wdata = v.wd;
        #(CLK_PERIOD/2 - 1);
        if (v.rd && !v.wr) check({tag, " rdata"}, rdata, v.erd);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check({tag, " status"}, status_o, v.est);
        check({tag, " irq"}, {7'b0, irq}, {7'b0, v.eirq});
        check({tag, " out_valid"}, {7'b0, out_valid}, {7'b0, v.ev});
        if (v.ev) check({tag, " out_byte"}, out_byte, v.eb);
    endtask

    task automatic reset_check();
        check("R1 status", status_o, 8'hD8);
        check("R1 irq", {7'b0, irq}, 8'h00);
        check("R1 out_valid", {7'b0, out_valid}, 8'h00);
        rd_en = 1'b1; addr = 2'd2; #1;
        check("R1 control", rdata, 8'h0C);
        addr = 2'd0; #1;
        check("R1 data", rdata, 8'hFF);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        reset_check();

        for (int i = 0; i < NV; i++) access(TBL[i]);

        // R11: a status write and read in one cycle must not clear the latch
        access('{1'b1, 1'b0, 2'd2, 8'h1C, 8'h00, 8'hD8, 1'b0, 8'h00, 1'b0, 4'd11});
        access('{1'b1, 1'b0, 2'd2, 8'h1C, 8'h00, 8'hD8, 1'b0, 8'h00, 1'b1, 4'd11});
        access('{1'b1, 1'b1, 2'd1, 8'h00, 8'h00, 8'hD8, 1'b0, 8'h00, 1'b1, 4'd11});
        access('{1'b0, 1'b1, 2'd1, 8'h00, 8'hD8, 8'hD8, 1'b0, 8'h00, 1'b0, 4'd8});

        // R1: reset in mid-handshake
        access('{1'b1, 1'b0, 2'd0, 8'h3C, 8'h00, 8'hD8, 1'b0, 8'h00, 1'b0, 4'd10});
        access('{1'b1, 1'b0, 2'd2, 8'h0D, 8'h00, 8'h58, 1'b1, 8'h3C, 1'b0, 4'd5});
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        reset_check();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule